// File: doc/BRIEF.md
# Eight-Input Running OR Network

This block takes eight single-bit flags and produces, for every position, the OR of that flag with all flags below it. Output bit k is therefore set when at least one input at index k or lower is set. A single scan gives the lowest set position together with everything above it as a thermometer code. Typical uses are leading-one masks, "anything pending so far" flags in a priority chain, and masks that fill every position above a given one.

The network is purely combinational and uses only 2-input OR operations. A parameter selects between two builds. The default is a logarithmic prefix tree: three levels, twelve 2-input ORs, with partial results shared between outputs. The other build is a serial chain: seven 2-input ORs in series, seven levels deep. Both builds give identical outputs. Output bit 0 is a plain wire from input bit 0 in both.

Top module: `prefix_or_net`

## Requirements
- R1: Output bit 0 equals input bit 0 for every input pattern.
- R2: With the default tree build (CHAIN = 0), output bit k equals the OR of input bits 0 through k, for every k from 1 to 7 and all 256 input patterns.
- R3: With the chain build (CHAIN = 1), output bit k equals the OR of input bits 0 through k, for every k from 1 to 7 and all 256 input patterns.
- R4: The output is monotone upward: if output bit k is 1, then output bit k+1 is also 1.
- R5: Output bit 7 equals the OR of all eight input bits.
- R6: When only input bit j is set, output bits j through 7 are 1 and all bits below j are 0.
- R7: An all-zero input gives an all-zero output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 8 | Input flags; bit 0 is the lowest position |
| y | output | 8 | Running OR; bit k is the OR of x[0] through x[k] |

## Verification
The case that is hardest to reach from the ports is a tree node that takes its partner's partial result from the wrong index. Such a fault shows only for patterns whose single lowest set bit sits in one particular block of the tree, and only at outputs beyond that block's boundary. The stimulus therefore walks all 256 patterns, one per clock, and compares every output bit of both builds against a loop-based running OR. It also drives each one-hot pattern separately, because those patterns isolate every source index the tree relies on.

// File: rtl/prefix_or_net.sv
module prefix_or_net #(
  parameter bit CHAIN = 1'b0
) (
  input  logic [7:0] x,
  output logic [7:0] y
);
  localparam int N  = 8;
  localparam int LV = $clog2(N);

  generate
    if (CHAIN) begin : g_chain
      logic [N-1:0] c;
      assign c[0] = x[0];
      for (genvar i = 1; i < N; i++) begin : g_link
        assign c[i] = c[i-1] | x[i];
      end
      assign y = c;
    end else begin : g_tree
      logic [LV:0][N-1:0] s;
      assign s[0] = x;
      for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < N; i++) begin : g_node
          if (((i >> l) & 1) == 1) begin : g_or
            localparam int SRC = ((i >> l) << l) - 1;
            assign s[l+1][i] = s[l][i] | s[l][SRC];
          end else begin : g_pass
            assign s[l+1][i] = s[l][i];
          end
        end
      end
      assign y = s[LV];
    end
  endgenerate
endmodule

// File: rtl/prefix_or_net_chk.sv
module prefix_or_net_chk (
  input logic [7:0] x,
  input logic [7:0] y
);
  always_comb begin
    // R1
    bit0_wire_chk: assert (y[0] == x[0]);
    // R5
    top_all_chk: assert (y[7] == (|x));
    // R7
    zero_in_chk: assert (x != 8'h00 || y == 8'h00);
    for (int k = 0; k < 7; k++) begin
      // R4
      monotone_chk: assert (!y[k] || y[k+1]);
    end
    for (int k = 0; k < 8; k++) begin
      // R2
      covers_in_chk: assert (!x[k] || y[k]);
    end
  end
endmodule

bind prefix_or_net prefix_or_net_chk chk (.x(x), .y(y));

// File: tb/prefix_or_net_test.sv
`timescale 1ns/1ps
module prefix_or_net_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] x = 8'h00;
  logic [7:0] y_tree, y_chain;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prefix_or_net #(.CHAIN(1'b0)) uut (.x(x), .y(y_tree));
  prefix_or_net #(.CHAIN(1'b1)) uut_chain (.x(x), .y(y_chain));

  function automatic logic [7:0] model(input logic [7:0] v);
    logic [7:0] r;
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < 8; k++) begin
      acc = acc | v[k];
      r[k] = acc;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s x=%02h actual=%02h expected=%02h", req, x, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(posedge clk);
    x = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset-time all-zero input
    check("R7", y_tree, 8'h00);
    check("R7", y_chain, 8'h00);

    for (int p = 0; p < 256; p++) begin
      apply(p[7:0]);
      check("R2", y_tree, model(x));
      check("R3", y_chain, model(x));
      check("R1", {7'd0, y_tree[0]}, {7'd0, x[0]});
      check("R5", {7'd0, y_tree[7]}, {7'd0, |x});
      check("R4", {7'd0, (y_tree & ~(y_tree << 1)) == 8'h00 ? 1'b0 : 1'b1},
            {7'd0, |x});
    end

    for (int j = 0; j < 8; j++) begin
      apply(8'h01 << j);
      check("R6", y_tree, 8'hFF << j);
      check("R6", y_chain, 8'hFF << j);
    end

    apply(8'h00);
    check("R7", y_tree, 8'h00);
    check("R7", y_chain, 8'h00);
    apply(8'h80);
    check("R5", y_tree, 8'h80);
    apply(8'hFF);
    check("R2", y_tree, 8'hFF);
    check("R3", y_chain, 8'hFF);
    apply(8'hA0);
    check("R2", y_tree, 8'hE0);
    apply(8'h18);
    check("R3", y_chain, 8'hF8);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule